// File: doc/BRIEF.md
# Indirect load address unit

This unit carries out register-indirect byte loads for an 8-bit microcontroller datapath. It inspects a 16-bit instruction word presented with a valid strobe and accepts only the nine indirect-load encodings. For an accepted word it reads one of three 16-bit pointer pairs from a 32 x 8 register file and forms a data-memory address. In the auto-modify forms it writes the adjusted pointer back, and finally it writes the fetched byte into the destination register.

The encoding is irregular: bit 12 must be set for every form using the pair at R27:R26, but for the other two pairs only the auto-modify forms set it. The unit checks that bit as a function of both the pointer field and the mode field. Any other word is reported on a one-cycle illegal flag and leaves all state untouched.

Each load takes two cycles after the strobe. The first cycle drives the memory read and the pointer writeback. The second captures the read data into the destination register and pulses `done`.

Top module: `ild_unit`

## Requirements
- R1: The destination register index is {instr[8], instr[7:4]}. The loaded byte is written to exactly that register.
- R2: instr[3:2] selects the pointer pair. 2'b11 selects R27:R26, 2'b10 selects R29:R28 and 2'b00 selects R31:R30. The higher-numbered register holds the high byte.
- R3: instr[1:0] selects the mode: 2'b00 plain, 2'b01 post-increment, 2'b10 pre-decrement. In plain mode the pointer pair is never written.
- R4: The R27:R26 forms are accepted only as 0x900C, 0x900D and 0x900E with the destination bits (8:4) free.
- R5: For R29:R28 and R31:R30, plain forms require bit 12 clear (0x8008, 0x8000) and auto-modify forms require bit 12 set (0x9009, 0x900A, 0x9001, 0x9002), with bits 8:4 free. Any other word raises `illegal` in the cycle after the strobe for one cycle and causes no register write and no memory read.
- R6: In post-increment mode the byte is read at the old pointer and the pointer becomes old + 1.
- R7: In pre-decrement mode the pointer becomes old - 1 and the byte is read at that new value.
- R8: Pointer arithmetic wraps modulo 2^16: 0xFFFF + 1 = 0x0000 and 0x0000 - 1 = 0xFFFF.
- R9: After an accepted strobe, the next cycle has `mem_re` high with the address and any pointer-pair write. The cycle after that has `done` high and the byte write. `busy` is high for both cycles.
- R10: When the destination register lies inside the selected pair in an auto-modify mode, the loaded byte overwrites that pointer byte, because it is written one cycle after the pointer.
- R11: A strobe presented while `busy` is high is ignored, and `busy` falls in the cycle after `done`.
- R12: While and after reset, `busy`, `done`, `illegal`, `rf_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 16 | Instruction word |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unrecognised word |
| rf_raddr | output | 5 | Index of the low register of the pair to read |
| rf_rdata_lo | input | 8 | Register file contents at rf_raddr |
| rf_rdata_hi | input | 8 | Register file contents at rf_raddr + 1 |
| rf_we | output | 1 | Register write enable |
| rf_wpair | output | 1 | Write rf_wdata as a pair at rf_waddr and rf_waddr + 1 |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 16 | Write data; only the low byte is used for a single write |
| mem_re | output | 1 | Data-memory read enable |
| mem_addr | output | 16 | Data-memory address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |

## Verification
The bench builds the unit with its defaults: 8-bit registers, 32 of them, and the shared single-adder pointer path. The 16-bit pointers therefore sit one step from their wrap points, and a single load starting at 0xFFFF or 0x0000 crosses them. The 32-entry file puts the destination field over its full range, so destinations that land inside the chosen pointer pair can be tested in both byte positions.

// File: rtl/ild_pkg.sv
package ild_pkg;

    localparam int INSTR_W   = 16;
    localparam int REG_IDX_W = 5;

    typedef enum logic [1:0] {
        PTR_HI_PAIR  = 2'b00,
        PTR_MID_PAIR = 2'b10,
        PTR_LO_PAIR  = 2'b11
    } ptr_e;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'b00,
        AM_POSTINC = 2'b01,
        AM_PREDEC  = 2'b10
    } amode_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'b00,
        PH_ISSUE   = 2'b01,
        PH_CAPTURE = 2'b10
    } phase_e;

    typedef struct packed {
        logic                 legal;
        logic [REG_IDX_W-1:0] rd;
        ptr_e                 ptr;
        amode_e               mode;
    } ld_op_t;

    localparam logic [REG_IDX_W-1:0] BASE_LO_PAIR  = 5'd26;
    localparam logic [REG_IDX_W-1:0] BASE_MID_PAIR = 5'd28;
    localparam logic [REG_IDX_W-1:0] BASE_HI_PAIR  = 5'd30;

    function automatic logic [REG_IDX_W-1:0] pair_base(input ptr_e p);
        case (p)
            PTR_LO_PAIR:  return BASE_LO_PAIR;
            PTR_MID_PAIR: return BASE_MID_PAIR;
            default:      return BASE_HI_PAIR;
        endcase
    endfunction

    // Bit 12 is required when the lowest pair is selected or the mode modifies the pointer.
    function automatic ld_op_t decode_ld(input logic [INSTR_W-1:0] w);
        ld_op_t o;
        logic   ptr_ok;
        logic   mode_ok;
        logic   b12_need;
        o.rd     = {w[8], w[7:4]};
        o.ptr    = ptr_e'(w[3:2]);
        o.mode   = amode_e'(w[1:0]);
        ptr_ok   = (w[3:2] != 2'b01);
        mode_ok  = (w[1:0] != 2'b11);
        b12_need = (w[3:2] == 2'b11) || (w[1:0] != 2'b00);
        o.legal  = (w[15:13] == 3'b100) && (w[11:9] == 3'b000)
                   && ptr_ok && mode_ok && (w[12] == b12_need);
        return o;
    endfunction

endpackage

// File: rtl/ild_decode.sv
module ild_decode
    import ild_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ld_op_t             op
);
    always_comb begin
        op = decode_ld(instr);
    end
endmodule

// File: rtl/ild_ptr_unit.sv
module ild_ptr_unit
    import ild_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [ADDR_W-1:0] ptr_old,
    input  amode_e            mode,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] ptr_new,
    output logic              wb_en
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [ADDR_W-1:0] delta;
            logic [ADDR_W-1:0] sum;
            always_comb begin
                delta   = (mode == AM_PREDEC) ? {ADDR_W{1'b1}} : ONE;
                sum     = ptr_old + delta;
                addr    = (mode == AM_PREDEC) ? sum : ptr_old;
                ptr_new = (mode == AM_PLAIN) ? ptr_old : sum;
            end
        end else begin : g_split
            logic [ADDR_W-1:0] up;
            logic [ADDR_W-1:0] down;
            always_comb begin
                up   = ptr_old + ONE;
                down = ptr_old - ONE;
                addr = (mode == AM_PREDEC) ? down : ptr_old;
                case (mode)
                    AM_POSTINC: ptr_new = up;
                    AM_PREDEC:  ptr_new = down;
                    default:    ptr_new = ptr_old;
                endcase
            end
        end
    endgenerate

    assign wb_en = (mode != AM_PLAIN);
endmodule

// File: rtl/ild_ctrl.sv
module ild_ctrl
    import ild_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   legal,
    output phase_e phase,
    output logic   accept,
    output logic   illegal
);
    logic idle;

    assign idle   = (phase == PH_IDLE);
    assign accept = idle && start && legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            illegal <= 1'b0;
        end else begin
            illegal <= idle && start && !legal;
            case (phase)
                PH_IDLE:    if (accept) phase <= PH_ISSUE;
                PH_ISSUE:   phase <= PH_CAPTURE;
                default:    phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ild_unit.sv
module ild_unit
    import ild_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int REG_CNT      = 32,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [15:0]                in_instr,
    output logic                       busy,
    output logic                       done,
    output logic                       illegal,
    output logic [$clog2(REG_CNT)-1:0] rf_raddr,
    input  logic [DATA_W-1:0]          rf_rdata_lo,
    input  logic [DATA_W-1:0]          rf_rdata_hi,
    output logic                       rf_we,
    output logic                       rf_wpair,
    output logic [$clog2(REG_CNT)-1:0] rf_waddr,
    output logic [2*DATA_W-1:0]        rf_wdata,
    output logic                       mem_re,
    output logic [2*DATA_W-1:0]        mem_addr,
    input  logic [DATA_W-1:0]          mem_rdata
);
    localparam int RIDX_W = $clog2(REG_CNT);
    localparam int ADDR_W = 2 * DATA_W;

    ld_op_t            dec_op;
    ld_op_t            op_q;
    phase_e            phase;
    logic              accept;
    logic [ADDR_W-1:0] ptr_old;
    logic [ADDR_W-1:0] calc_addr;
    logic [ADDR_W-1:0] calc_ptr;
    logic              calc_wb;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              wb_q;
    logic [RIDX_W-1:0] base_q;

    ild_decode u_decode (
        .instr (in_instr),
        .op    (dec_op)
    );

    ild_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (in_valid),
        .legal   (dec_op.legal),
        .phase   (phase),
        .accept  (accept),
        .illegal (illegal)
    );

    assign rf_raddr = (phase == PH_IDLE) ? RIDX_W'(pair_base(dec_op.ptr)) : base_q;
    assign ptr_old  = {rf_rdata_hi, rf_rdata_lo};

    ild_ptr_unit #(
        .ADDR_W       (ADDR_W),
        .SHARED_ADDER (SHARED_ADDER)
    ) u_ptr (
        .ptr_old (ptr_old),
        .mode    (dec_op.mode),
        .addr    (calc_addr),
        .ptr_new (calc_ptr),
        .wb_en   (calc_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            addr_q <= '0;
            ptr_q  <= '0;
            wb_q   <= 1'b0;
            base_q <= '0;
        end else if (accept) begin
            op_q   <= dec_op;
            addr_q <= calc_addr;
            ptr_q  <= calc_ptr;
            wb_q   <= calc_wb;
            base_q <= RIDX_W'(pair_base(dec_op.ptr));
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign done     = (phase == PH_CAPTURE);
    assign mem_re   = (phase == PH_ISSUE);
    assign mem_addr = addr_q;

    // Pointer pair goes out in the issue cycle, the byte one cycle later, so the byte wins on overlap.
    always_comb begin
        rf_we    = 1'b0;
        rf_wpair = 1'b0;
        rf_waddr = base_q;
        rf_wdata = ptr_q;
        if (phase == PH_ISSUE) begin
            rf_we    = wb_q;
            rf_wpair = 1'b1;
        end else if (phase == PH_CAPTURE) begin
            rf_we    = 1'b1;
            rf_waddr = RIDX_W'(op_q.rd);
            rf_wdata = ADDR_W'(mem_rdata);
        end
    end
endmodule

// File: rtl/ild_unit_chk.sv
module ild_unit_chk
    import ild_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              rf_we,
    input logic              rf_wpair,
    input logic [ADDR_W-1:0] rf_wdata,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input amode_e            op_mode
);
    assert_reset_quiet_R12: assert property (@(posedge clk)
        rst |=> (!busy && !done && !illegal && !mem_re && !rf_we));

    assert_issue_then_capture_R9: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (done && rf_we && !rf_wpair));

    assert_capture_after_issue_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_re));

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_re, done, illegal}));

    assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!busy && !rf_we && !mem_re));

    assert_pair_write_modes_R3: assert property (@(posedge clk) disable iff (rst)
        (rf_we && rf_wpair) |-> (mem_re && op_mode != AM_PLAIN));

    assert_postinc_wb_R6: assert property (@(posedge clk) disable iff (rst)
        (rf_we && rf_wpair && op_mode == AM_POSTINC) |-> (rf_wdata == mem_addr + ADDR_W'(1)));

    assert_predec_wb_R7: assert property (@(posedge clk) disable iff (rst)
        (rf_we && rf_wpair && op_mode == AM_PREDEC) |-> (rf_wdata == mem_addr));

    assert_done_ends_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

bind ild_unit ild_unit_chk #(
    .ADDR_W (ADDR_W),
    .RIDX_W (RIDX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .rf_we    (rf_we),
    .rf_wpair (rf_wpair),
    .rf_wdata (rf_wdata),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .op_mode  (op_q.mode)
);

// File: tb/ild_unit_tb.sv
`timescale 1ns/1ps
module ild_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = 16'h0000;
    logic        busy, done, illegal;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [7:0]  rf_rdata_lo, rf_rdata_hi;
    logic        rf_we, rf_wpair, mem_re;
    logic [15:0] rf_wdata, mem_addr;
    logic [7:0]  mem_rdata;

    logic [7:0]  regs [32];
    logic [7:0]  ref_regs [32];
    logic        pre_we = 1'b0;
    logic [4:0]  pre_idx = 5'd0;
    logic [7:0]  pre_val = 8'd0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ild_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .busy(busy), .done(done), .illegal(illegal),
        .rf_raddr(rf_raddr), .rf_rdata_lo(rf_rdata_lo), .rf_rdata_hi(rf_rdata_hi),
        .rf_we(rf_we), .rf_wpair(rf_wpair), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] memfn(input logic [15:0] a);
        return (a[7:0] * 8'd3 + a[15:8]) ^ 8'h3C;
    endfunction

    assign rf_rdata_lo = regs[rf_raddr];
    assign rf_rdata_hi = regs[rf_raddr + 5'd1];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) regs[i] <= 8'h00;
        end else if (pre_we) begin
            regs[pre_idx] <= pre_val;
        end else if (rf_we) begin
            regs[rf_waddr] <= rf_wdata[7:0];
            if (rf_wpair) regs[rf_waddr + 5'd1] <= rf_wdata[15:8];
        end
        if (mem_re) mem_rdata <= memfn(mem_addr);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int reg_mismatches();
        int n = 0;
        for (int i = 0; i < 32; i++) if (regs[i] !== ref_regs[i]) n++;
        return n;
    endfunction

    task automatic set_reg(input int idx, input logic [7:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_idx = 5'(idx); pre_val = v;
        @(negedge clk);
        pre_we = 1'b0;
        ref_regs[idx] = v;
    endtask

    task automatic set_ptr(input int base, input logic [15:0] v);
        set_reg(base, v[7:0]);
        set_reg(base + 1, v[15:8]);
    endtask

    function automatic bit ref_legal(input logic [15:0] w);
        logic [15:0] m;
        m = w & 16'hFE0F;
        return (m == 16'h900C) || (m == 16'h900D) || (m == 16'h900E) ||
               (m == 16'h8008) || (m == 16'h9009) || (m == 16'h900A) ||
               (m == 16'h8000) || (m == 16'h9001) || (m == 16'h9002);
    endfunction

    // Full load with reference-model update and cycle-by-cycle checks.
    task automatic run_load(input logic [15:0] w, input string req);
        int base, rd;
        logic [15:0] oldp, addr, newp;
        base = (w[3:2] == 2'b11) ? 26 : (w[3:2] == 2'b10) ? 28 : 30;
        rd   = {w[8], w[7:4]};
        oldp = {ref_regs[base + 1], ref_regs[base]};
        addr = (w[1:0] == 2'b10) ? oldp - 16'd1 : oldp;
        newp = (w[1:0] == 2'b01) ? oldp + 16'd1 : (w[1:0] == 2'b10) ? oldp - 16'd1 : oldp;
        @(negedge clk);
        in_valid = 1'b1; in_instr = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy && mem_re && !illegal, {req, " R9 issue cycle"}, {busy, mem_re, illegal}, 3'b110);
        chk(mem_addr == addr, {req, " address"}, mem_addr, addr);
        if (w[1:0] != 2'b00) begin
            ref_regs[base]     = newp[7:0];
            ref_regs[base + 1] = newp[15:8];
        end
        ref_regs[rd] = memfn(addr);
        @(negedge clk);
        chk(busy && done, {req, " R9 capture cycle"}, {busy, done}, 2'b11);
        @(negedge clk);
        chk(!busy && !done, {req, " R11 back to idle"}, {busy, done}, 2'b00);
        chk(reg_mismatches() == 0, {req, " register file"}, reg_mismatches(), 0);
    endtask

    task automatic run_illegal(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_instr = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk(ref_legal(w) == 1'b0, "R5 bench table", w, 0);
        chk(illegal && !busy && !mem_re, "R5 illegal pulse", {illegal, busy, mem_re}, 3'b100);
        @(negedge clk);
        chk(!illegal && !busy, "R5 illegal one cycle", {illegal, busy}, 2'b00);
        chk(reg_mismatches() == 0, "R5 no register change", reg_mismatches(), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !illegal && !rf_we && !mem_re, "R12 reset outputs",
            {busy, done, illegal, rf_we, mem_re}, 0);
    endtask

    task automatic t_nine_forms();
        set_ptr(26, 16'h1234);
        set_ptr(28, 16'h4567);
        set_ptr(30, 16'h89AB);
        run_load(16'h900C | (16'd3 << 4), "R4 R2 R1 lowest pair plain");
        run_load(16'h900D | (16'd17 << 4), "R4 R6 lowest pair postinc");
        run_load(16'h900E | (16'd5 << 4), "R4 R7 lowest pair predec");
        run_load(16'h8008 | (16'd20 << 4), "R5 R3 middle pair plain");
        run_load(16'h9009 | (16'd0 << 4), "R5 R6 middle pair postinc");
        run_load(16'h900A | (16'd25 << 4), "R5 R7 middle pair predec");
        run_load(16'h8000 | (16'd24 << 4), "R5 R2 highest pair plain");
        run_load(16'h9001 | (16'd10 << 4), "R5 R6 highest pair postinc");
        run_load(16'h9002 | (16'd1 << 4), "R5 R7 highest pair predec");
    endtask

    task automatic t_wrap();
        set_ptr(26, 16'hFFFF);
        run_load(16'h900D | (16'd2 << 4), "R8 postinc wraps to 0000");
        set_ptr(30, 16'h0000);
        run_load(16'h9002 | (16'd4 << 4), "R8 predec wraps to FFFF");
        set_ptr(28, 16'hFFFF);
        run_load(16'h9009 | (16'd6 << 4), "R8 middle postinc wrap");
        set_ptr(28, 16'h0000);
        run_load(16'h900A | (16'd7 << 4), "R8 middle predec wrap");
    endtask

    task automatic t_overlap();
        set_ptr(26, 16'h12FF);
        run_load(16'h900D | (16'd26 << 4), "R10 dest is low pointer byte");
        chk(regs[26] == memfn(16'h12FF) && regs[27] == 8'h13, "R10 byte wins over pointer low",
            {regs[27], regs[26]}, {8'h13, memfn(16'h12FF)});
        set_ptr(30, 16'h4000);
        run_load(16'h9002 | (16'd31 << 4), "R10 dest is high pointer byte");
        chk(regs[31] == memfn(16'h3FFF) && regs[30] == 8'hFF, "R10 byte wins over pointer high",
            {regs[31], regs[30]}, {memfn(16'h3FFF), 8'hFF});
    endtask

    task automatic t_illegal();
        run_illegal(16'h9004);
        run_illegal(16'h800C);
        run_illegal(16'h8009);
        run_illegal(16'h9008);
        run_illegal(16'h9003);
        run_illegal(16'h920C);
        run_illegal(16'hA00C);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] p;
        set_ptr(28, 16'h2000);
        p = 16'h2000;
        @(negedge clk);
        in_valid = 1'b1; in_instr = 16'h9009 | (16'd9 << 4);
        @(negedge clk);
        in_instr = 16'h9001 | (16'd11 << 4);
        chk(mem_re && mem_addr == p, "R11 first load issued", mem_addr, p);
        @(negedge clk);
        chk(done, "R11 first load completes", done, 1);
        in_valid = 1'b0;
        ref_regs[28] = 8'h01; ref_regs[29] = 8'h20;
        ref_regs[9]  = memfn(p);
        @(negedge clk);
        chk(!busy && !mem_re, "R11 strobe during busy ignored", {busy, mem_re}, 0);
        chk(reg_mismatches() == 0, "R11 only first load applied", reg_mismatches(), 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) ref_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_nine_forms();
        t_wrap();
        t_overlap();
        t_illegal();
        t_busy_ignore();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule